// File: doc/BRIEF.md
# Pipelined SPI ADC Channel Sequencer

This block drives a multi-channel successive-approximation ADC over a four-wire SPI link and turns single-channel read requests into right-aligned conversion results. The converter takes a 14-bit configuration word in every 16-bit frame. The data it returns in a frame comes from the conversion that was configured two frames earlier. The sequencer keeps a shadow copy of the configuration word and patches only its channel field on each request. It sends as many frames as that two-deep pipeline needs, then presents the result with a one-cycle done strobe.

After reset the block writes a complete boot configuration. It then performs two discarded channel-0 reads, and only after these does it raise its request ready. Each frame is followed by an idle gap, counted in clock cycles, that keeps the converter's minimum spacing between frames.

The request side is a valid/ready stream. A request transfers in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low from the transfer until the result strobe has been issued and the gap that follows the last frame has elapsed. A requester holding `req_valid` while ready is low is simply stalled. The result side has no back-pressure: `res_valid` is a single-cycle strobe that the consumer must capture.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and directly after it, `spi_cs_n` is high, `spi_sclk` is low, `req_ready` is low and `res_valid` is low.
- R2: After reset, exactly five frames are sent before `req_ready` first rises: one boot configuration frame and two discarded channel-0 reads of two frames each. All five carry channel 0, and none raises `res_valid`.
- R3: Every frame transmits the configuration word left-aligned, MSB first, with frame bits 1:0 zero. The word is laid out as follows:
  - bit 13: update flag, 1
  - bits 12:10: input type, 3'b111
  - bits 9:7: channel
  - bit 6: full bandwidth, 1
  - bits 5:3: reference, {0, ref_code}
  - bits 2:1: sequencer, 00
  - bit 0: readback disable, 1
- R4: A request for a channel different from the previous read's channel sends three frames, all carrying the new channel. The third frame's data is the result.
- R5: A request for the same channel as the previous read sends two frames. The second frame's data is the result.
- R6: One clock after the data frame ends, `res_valid` pulses for exactly one cycle. `res_data` then holds the 16 received bits shifted right by 16-RES_BITS, and `res_chan` holds the requested channel.
- R7: Each frame holds `spi_cs_n` low for exactly 16 rising `spi_sclk` edges. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only with `spi_cs_n` falling or `spi_sclk` falling, and `spi_miso` is sampled on the rising edge.
- R8: Between the end of one frame and the start of the next, `spi_cs_n` stays high for at least GAP_CYCLES clock cycles.
- R9: `req_ready` is low from request acceptance through the result strobe. A `req_valid` raised while ready is low starts no frame.
- R10: `ref_code` is captured only while reset is held. A later change does not alter the reference field of any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_code | input | 2 | Reference selection: 0 int 2.5 V, 1 int 4.096 V, 2 external, 3 external buffered |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request can be accepted |
| req_chan | input | 3 | Channel to read |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_BITS | Right-aligned conversion result |
| res_chan | output | 3 | Channel of the result |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial configuration out |
| spi_miso | input | 1 | Serial conversion data in |

## Verification
The hardest situation to reach from the ports is telling a three-frame read from a two-frame read by its data rather than by its frame count. A wrong skip decision still produces a plausible number, just from the wrong conversion. The bench's converter model stamps every returned word with the channel configured two frames earlier and with the index of the frame it returns in. Alternating runs of repeated and changing channels therefore expose any extra or missing frame as a wrong channel or wrong stamp in the result. The model also receives requests raised while ready is low and a reference input changed after reset, so that nothing may leak into the frames.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W   = 14;
  localparam int FRAME_W = 16;
  localparam int CH_W    = 3;

  // configuration word field positions (decoded by the converter)
  localparam int UPD_BIT   = 13;
  localparam int ITYPE_LSB = 10;
  localparam int CHAN_LSB  = 7;
  localparam int BW_BIT    = 6;
  localparam int REFS_LSB  = 3;
  localparam int SEQ_LSB   = 1;
  localparam int RBN_BIT   = 0;

  localparam logic [2:0] ITYPE_UNI_GND = 3'd7;

  typedef enum logic [1:0] {EN_IDLE, EN_LOW, EN_HIGH, EN_GAP} eng_state_t;
  typedef enum logic [1:0] {ST_ISSUE, ST_FLIGHT, ST_IDLE} seq_state_t;

  function automatic logic [CFG_W-1:0] boot_word(input logic [1:0] refc);
    logic [CFG_W-1:0] w;
    w = '0;
    w[UPD_BIT]                 = 1'b1;
    w[ITYPE_LSB +: 3]          = ITYPE_UNI_GND;
    w[CHAN_LSB +: CH_W]        = '0;
    w[BW_BIT]                  = 1'b1;
    w[REFS_LSB +: 3]           = {1'b0, refc};
    w[SEQ_LSB +: 2]            = 2'b00;
    w[RBN_BIT]                 = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/adc_cfg_shadow.sv
module adc_cfg_shadow
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ref_code,
  input  logic                chan_we,
  input  logic [CH_W-1:0]     chan_in,
  output logic [FRAME_W-1:0]  frame_word
);
  localparam int PAD_W = FRAME_W - CFG_W;

  logic [CFG_W-1:0] shadow_q;

  // reference is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= boot_word(ref_code);
    end else if (chan_we) begin
      shadow_q[CHAN_LSB +: CH_W] <= chan_in;
    end
  end

  assign frame_word = {shadow_q, {PAD_W{1'b0}}};
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 400
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               ready,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_ALL  = BIT_W'(FRAME_W);

  eng_state_t         state;
  logic [DIV_W-1:0]   div_cnt;
  logic [GAP_W-1:0]   gap_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] tx_sr;
  logic [FRAME_W-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= EN_IDLE;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      div_cnt  <= '0;
      gap_cnt  <= '0;
      bit_cnt  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        EN_IDLE: begin
          if (start) begin
            cs_n    <= 1'b0;
            mosi    <= tx_word[FRAME_W-1];
            tx_sr   <= tx_word << 1;
            div_cnt <= '0;
            bit_cnt <= '0;
            state   <= EN_LOW;
          end
        end
        EN_LOW: begin
          if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            sclk    <= 1'b1;
            rx_sr   <= {rx_sr[FRAME_W-2:0], miso};
            bit_cnt <= bit_cnt + 1'b1;
            state   <= EN_HIGH;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        EN_HIGH: begin
          if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
            if (bit_cnt == BIT_ALL) begin
              cs_n     <= 1'b1;
              mosi     <= 1'b0;
              rx_valid <= 1'b1;
              rx_word  <= rx_sr;
              gap_cnt  <= '0;
              state    <= EN_GAP;
            end else begin
              mosi  <= tx_sr[FRAME_W-1];
              tx_sr <= tx_sr << 1;
              state <= EN_LOW;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        EN_GAP: begin
          if (gap_cnt == GAP_LAST) state <= EN_IDLE;
          else                     gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= EN_IDLE;
      endcase
    end
  end

  assign ready = (state == EN_IDLE);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 14
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [CH_W-1:0]     req_chan,
  output logic                req_ready,
  input  logic                eng_ready,
  output logic                eng_start,
  input  logic                rx_valid,
  input  logic [FRAME_W-1:0]  rx_word,
  output logic                chan_we,
  output logic [CH_W-1:0]     chan_sel,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic [CH_W-1:0]     res_chan
);
  localparam int SHIFT = FRAME_W - RES_BITS;

  seq_state_t       state;
  logic [1:0]       frames_left;
  logic [1:0]       boot_left;
  logic             dummy;
  logic [CH_W-1:0]  cur_chan;
  logic [CH_W-1:0]  last_chan;
  logic [RES_BITS-1:0] aligned;
  logic             accept;

  generate
    if (SHIFT == 0) begin : g_full
      assign aligned = rx_word;
    end else begin : g_shift
      assign aligned = rx_word[FRAME_W-1:SHIFT];
    end
  endgenerate

  assign req_ready = (state == ST_IDLE) && eng_ready;
  assign accept    = req_valid && req_ready;
  assign chan_we   = accept;
  assign chan_sel  = req_chan;
  assign eng_start = (state == ST_ISSUE) && eng_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_ISSUE;   // boot configuration frame
      frames_left <= 2'd1;
      boot_left   <= 2'd2;       // two discarded channel-0 reads
      dummy       <= 1'b1;
      cur_chan    <= '0;
      last_chan   <= '0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_chan    <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_ISSUE: if (eng_start) state <= ST_FLIGHT;
        ST_FLIGHT: begin
          if (rx_valid) begin
            if (frames_left == 2'd1) begin
              last_chan <= cur_chan;
              if (!dummy) begin
                res_valid <= 1'b1;
                res_data  <= aligned;
                res_chan  <= cur_chan;
              end
              if (boot_left != 2'd0) begin
                boot_left   <= boot_left - 1'b1;
                frames_left <= 2'd2;
                state       <= ST_ISSUE;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              frames_left <= frames_left - 1'b1;
              state       <= ST_ISSUE;
            end
          end
        end
        ST_IDLE: begin
          if (accept) begin
            cur_chan    <= req_chan;
            frames_left <= (req_chan == last_chan) ? 2'd2 : 2'd3;
            dummy       <= 1'b0;
            state       <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS   = 14,
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 400
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ref_code,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_chan,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic [2:0]          res_chan,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi,
  input  logic                spi_miso
);
  logic               eng_ready, eng_start, rx_valid, chan_we;
  logic [FRAME_W-1:0] rx_word, tx_word;
  logic [CH_W-1:0]    chan_sel;

  adc_cfg_shadow i_shadow (
    .clk(clk), .rst_n(rst_n), .ref_code(ref_code),
    .chan_we(chan_we), .chan_in(chan_sel), .frame_word(tx_word)
  );

  adc_seq_fsm #(.RES_BITS(RES_BITS)) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready),
    .eng_ready(eng_ready), .eng_start(eng_start),
    .rx_valid(rx_valid), .rx_word(rx_word),
    .chan_we(chan_we), .chan_sel(chan_sel),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan)
  );

  adc_spi_frame #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP_CYCLES)) i_spi (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_word(tx_word),
    .ready(eng_ready), .rx_valid(rx_valid), .rx_word(rx_word),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int GAP_CYCLES = 400
)(
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic res_valid,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi
);
  localparam int CW = $clog2(GAP_CYCLES + 2) + 1;

  logic [CW-1:0] hi_cnt;
  logic [4:0]    rise_cnt;
  logic          sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= CW'(GAP_CYCLES);
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= spi_sclk;
      if (!spi_cs_n)                        hi_cnt <= '0;
      else if (hi_cnt < CW'(GAP_CYCLES))    hi_cnt <= hi_cnt + 1'b1;
      if (spi_cs_n)                         rise_cnt <= '0;
      else if (spi_sclk && !sclk_q)         rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_sixteen_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> rise_cnt == 5'd16);

  assert_mosi_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(!spi_cs_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> hi_cnt >= CW'(GAP_CYCLES));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_not_ready_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.GAP_CYCLES(GAP_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int RES = 14;
  localparam int GAP = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ref_code = 2'd1;
  logic req_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic req_ready, res_valid, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic [RES-1:0] res_data;
  logic [2:0] res_chan;

  always #2.5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_code(ref_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- converter model ----------------
  logic [15:0] cfg_hist [0:1023];
  int   k = 0;            // frames completed
  logic [15:0] miso_sr, mosi_sr;
  int   nbits;
  logic [2:0] exp_frame_q[$];
  logic [1:0] ref_boot = 2'd1;

  function automatic logic [15:0] stamp(input int idx, input logic [2:0] ch);
    logic [10:0] i11;
    i11 = idx[10:0];
    return {ch, i11, 2'b00};
  endfunction

  function automatic logic [15:0] frame_data(input int idx);
    if (idx < 2) return 16'h0000;
    return stamp(idx, cfg_hist[idx-2][11:9]);
  endfunction

  always @(negedge spi_cs_n) begin
    miso_sr  = frame_data(k);
    spi_miso = miso_sr[15];
    mosi_sr  = '0;
    nbits    = 0;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    mosi_sr = {mosi_sr[14:0], spi_mosi};
    nbits++;
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    miso_sr  = miso_sr << 1;
    spi_miso = miso_sr[15];
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    logic [2:0]  ech;
    logic [15:0] ew;
    cfg_hist[k] = mosi_sr;
    check(nbits == 16, "R7 clocks per frame", nbits, 16);
    if (exp_frame_q.size() == 0) begin
      check(0, "R9 unexpected frame", k, -1);
    end else begin
      ech = exp_frame_q.pop_front();
      ew  = {1'b1, 3'b111, ech, 1'b1, 1'b0, ref_boot, 2'b00, 1'b1, 2'b00};
      check(mosi_sr == ew, "R3/R4/R10 frame word", mosi_sr, ew);
    end
    k++;
  end

  // gap measurement (R8)
  int hi_cnt = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && cs_prev && !spi_cs_n && k > 0)
      check(hi_cnt >= GAP, "R8 inter-frame gap", hi_cnt, GAP);
    hi_cnt  = spi_cs_n ? hi_cnt + 1 : 0;
    cs_prev = spi_cs_n;
  end

  // ---------------- scoreboard ----------------
  logic [RES-1:0] exp_data_q[$];
  logic [2:0]     exp_chan_q[$];
  int total = 5;
  logic [2:0] last_ch = 3'd0;

  always @(negedge clk) if (rst_n && res_valid) begin
    if (exp_data_q.size() == 0) begin
      check(0, "R6 unexpected result", res_data, -1);
    end else begin
      logic [RES-1:0] ed;
      logic [2:0] ec;
      ed = exp_data_q.pop_front();
      ec = exp_chan_q.pop_front();
      check(res_data == ed, "R4/R5/R6 result data", res_data, ed);
      check(res_chan == ec, "R6 result channel", res_chan, ec);
    end
  end

  task automatic do_read(input logic [2:0] ch);
    int nfr;
    logic [15:0] w;
    do @(negedge clk); while (!req_ready);
    nfr = (ch == last_ch) ? 2 : 3;
    for (int i = 0; i < nfr; i++) exp_frame_q.push_back(ch);
    total += nfr;
    w = stamp(total - 1, ch);
    exp_data_q.push_back(RES'(w >> (16 - RES)));
    exp_chan_q.push_back(ch);
    last_ch = ch;
    req_valid = 1'b1;
    req_chan  = ch;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) exp_frame_q.push_back(3'd0);
    repeat (4) @(negedge clk);
    check(spi_cs_n && !spi_sclk && !req_ready && !res_valid, "R1 reset state",
          {spi_cs_n, spi_sclk, req_ready, res_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_ready && !res_valid, "R1 after reset", {req_ready, res_valid}, 0);
    wait_idle();
    check(k == 5, "R2 boot frames before ready", k, 5);
    check(exp_data_q.size() == 0, "R2 no boot result", 0, 0);

    do_read(3'd3);            // new channel: 3 frames (R4)
    wait_idle();
    check(k == total, "R4 frame count new channel", k, total);
    do_read(3'd3);            // same channel: 2 frames (R5)
    wait_idle();
    check(k == total, "R5 frame count same channel", k, total);
    do_read(3'd5);
    do_read(3'd5);
    do_read(3'd5);
    do_read(3'd0);
    do_read(3'd7);

    ref_code = 2'd2;          // R10: must not reach the frames
    do_read(3'd7);
    do_read(3'd1);

    // R9: request raised while busy is ignored
    do_read(3'd2);
    repeat (30) @(negedge clk);
    req_chan = 3'd6; req_valid = 1'b1;
    @(negedge clk);
    check(!req_ready, "R9 ready low while busy", req_ready, 0);
    req_valid = 1'b0;
    wait_idle();
    check(k == total, "R9 no extra frame", k, total);

    for (int c = 0; c < 8; c++) begin
      do_read(3'(c));
      if (c[0]) do_read(3'(c));
    end
    wait_idle();
    repeat (10) @(negedge clk);
    check(k == total, "R4/R5 final frame count", k, total);
    check(exp_data_q.size() == 0, "R6 all results seen", exp_data_q.size(), 0);
    check(exp_frame_q.size() == 0, "R3 all frames seen", exp_frame_q.size(), 0);
    finish_run();
  end
endmodule